// File: doc/BRIEF.md
# Interpolator Rate Configuration Encoder

This unit converts a requested integer interpolation rate into a packed 16-bit configuration word for a third-order interpolating filter. It approximates the rate as a small floating-point pair: a 6-bit mantissa and a 4-bit exponent. It then picks the smallest gain-compensation shift that stops the filter's cubic gain from clipping. Along with the word, it reports the rate that is actually achieved.

The host pulses `start_i` with a rate on `rate_i`. The unit then runs for a short, rate-dependent number of cycles:

- one cycle for each normalising shift,
- two cycles for the multiplies,
- one cycle for the logarithm search,
- one cycle to publish the result.

When it finishes, it raises `done_o` for one cycle. The outputs keep their values until the next completed request. A request outside the legal range ends with `err_o` set and a cleared word.

Top module: `rate_cfg_encoder`

## Requirements
- R1: A rate of 0 or any rate above 65536 completes with `err_o`=1, `cfg_o`=0 and `rate_act_o`=0. A legal rate (1 to 65536) completes with `err_o`=0.
- R2: The mantissa starts as the rate and is halved (floor) while it exceeds 64. The exponent counts the halvings, so the final mantissa lies in 1..64.
- R3: The gain exponent is the smallest g with 2^g ≥ mantissa³, plus three times the exponent.
- R4: Word layout: bits [5:0] hold mantissa−1, bits [9:6] hold the exponent, bits [15:10] hold the gain exponent.
- R5: `rate_act_o` equals the mantissa shifted left by the exponent.
- R6: For a legal rate, the overall gain rate_act³/2^g is exactly 1 when rate_act is a power of two. Otherwise it lies strictly between 1/2 and 1.
- R7: `done_o` is high for exactly one cycle per accepted request. `cfg_o`, `rate_act_o` and `err_o` change only in a cycle where `done_o` is high.
- R8: A start pulse that arrives while a request is in progress is ignored. The running request finishes with its own result, and only one done pulse is produced.
- R9: After reset, `cfg_o`, `rate_act_o`, `done_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| rate_i | input | 17 | Requested interpolation rate |
| cfg_o | output | 16 | Packed configuration word |
| rate_act_o | output | 17 | Rate actually achieved |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was out of range |

## Verification
Most internal faults reach the ports in the very next done pulse:

- a miscounted shift shows up as a wrong exponent field and a wrong achieved rate;
- a wrong cube or a bad power-of-two correction shows up as a gain exponent that is off by one;
- that off-by-one breaks the unity or half-to-unity gain bound.

A state machine that re-arms while busy is exposed by an extra done pulse, or by a result that belongs to the intruding rate. A publish strobe that lingers shows up as a done pulse lasting two cycles.

// File: rtl/rate_cfg_encoder.sv
module rate_cfg_encoder #(
  parameter int RATE_W = 17,
  parameter int MANT_W = 6,
  parameter int EXP_W  = 4,
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [MANT_W+EXP_W+GAIN_W-1:0] cfg_o,
  output logic [RATE_W-1:0] rate_act_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CFG_W  = MANT_W + EXP_W + GAIN_W;
  localparam int CUBE_W = 3 * MANT_W + 1;
  localparam int LOG_W  = $clog2(CUBE_W + 1);
  localparam logic [RATE_W-1:0] MANT_MAX = RATE_W'(1) << MANT_W;
  localparam logic [RATE_W-1:0] RATE_MAX = RATE_W'(1) << (RATE_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_NORM, S_SQ, S_CUBE, S_LOG, S_FIN} state_t;
  state_t state;

  logic [RATE_W-1:0] mant;
  logic [EXP_W-1:0]  expo;
  logic [CUBE_W-1:0] prod;
  logic [GAIN_W-1:0] gexp;
  logic              bad;
  logic [LOG_W-1:0]  msb;
  logic              pow2;
  logic [LOG_W-1:0]  clog;

  always_comb begin
    msb = '0;
    for (int i = 0; i < CUBE_W; i++)
      if (prod[i]) msb = LOG_W'(i);
  end

  assign pow2 = ((prod & (prod - CUBE_W'(1))) == '0);
  assign clog = pow2 ? msb : msb + LOG_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mant       <= '0;
      expo       <= '0;
      prod       <= '0;
      gexp       <= '0;
      bad        <= 1'b0;
      cfg_o      <= '0;
      rate_act_o <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          mant  <= rate_i;
          expo  <= '0;
          bad   <= (rate_i == '0) || (rate_i > RATE_MAX);
          state <= ((rate_i == '0) || (rate_i > RATE_MAX)) ? S_FIN : S_NORM;
        end
        S_NORM: if (mant > MANT_MAX) begin
          mant <= mant >> 1;
          expo <= expo + EXP_W'(1);
        end else begin
          state <= S_SQ;
        end
        S_SQ: begin
          prod  <= CUBE_W'(mant * mant);
          state <= S_CUBE;
        end
        S_CUBE: begin
          prod  <= CUBE_W'(prod * CUBE_W'(mant));
          state <= S_LOG;
        end
        S_LOG: begin
          gexp  <= GAIN_W'(clog) + GAIN_W'(expo) * GAIN_W'(3);
          state <= S_FIN;
        end
        S_FIN: begin
          done_o <= 1'b1;
          err_o  <= bad;
          if (bad) begin
            cfg_o      <= '0;
            rate_act_o <= '0;
          end else begin
            cfg_o      <= {gexp, expo, MANT_W'(mant - RATE_W'(1))};
            rate_act_o <= mant << expo;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(cfg_o) && $stable(rate_act_o) && $stable(err_o)));
  // R1
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (cfg_o == '0 && rate_act_o == '0));
  // R2
  mant_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_SQ) |-> (mant >= RATE_W'(1) && mant <= MANT_MAX));
  // R3
  gain_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |->
      (cfg_o[CFG_W-1 -: GAIN_W] >= GAIN_W'(cfg_o[MANT_W +: EXP_W]) * GAIN_W'(3)));
endmodule

// File: tb/rate_cfg_encoder_tb_top.sv
module rate_cfg_encoder_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        start_i = 0;
  logic [16:0] rate_i = '0;
  logic [15:0] cfg_o;
  logic [16:0] rate_act_o;
  logic        done_o, err_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rate_cfg_encoder dut_i (.clk(clk), .rst(rst), .start_i(start_i), .rate_i(rate_i),
    .cfg_o(cfg_o), .rate_act_o(rate_act_o), .done_o(done_o), .err_o(err_o));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int r, output logic [15:0] cfg, output int act, output bit bad);
    int m = r, e = 0, g = 0;
    longint c;
    bad = (r == 0) || (r > 65536);
    if (bad) begin
      cfg = 0;
      act = 0;
      return;
    end
    while (m > 64) begin
      m = m >> 1;
      e++;
    end
    c = longint'(m) * m * m;
    while ((64'sd1 <<< g) < c) g++;
    g += 3 * e;
    cfg = {g[5:0], e[3:0], 6'(m - 1)};
    act = m << e;
  endtask

  task automatic run(input int r, input bit inject);
    logic [15:0] ecfg;
    int eact, cyc = 0, dones = 0;
    bit ebad;
    longint a3;
    model(r, ecfg, eact, ebad);
    @(negedge clk);
    start_i = 1;
    rate_i = 17'(r);
    @(negedge clk);
    start_i = 0;
    while (!done_o && cyc < 100) begin
      if (inject && cyc == 1) begin
        start_i = 1;
        rate_i = 17'd777;
      end else start_i = 0;
      @(negedge clk);
      cyc++;
    end
    start_i = 0;
    if (!done_o) begin
      chk(0, "R7 watchdog", cyc, 0);
      return;
    end
    chk(err_o == ebad, "R1 err", err_o, ebad);
    chk(cfg_o == ecfg, "R2 R3 R4 cfg", cfg_o, ecfg);
    chk(rate_act_o == 17'(eact), "R5 rate_act", rate_act_o, eact);
    if (!ebad) begin
      a3 = longint'(rate_act_o) * rate_act_o * rate_act_o;
      if ((rate_act_o & (rate_act_o - 1)) == 0)
        chk(a3 == (64'sd1 <<< cfg_o[15:10]), "R6 unity", a3, 64'sd1 <<< cfg_o[15:10]);
      else
        chk(a3 < (64'sd1 <<< cfg_o[15:10]) && 2 * a3 > (64'sd1 <<< cfg_o[15:10]),
            "R6 bound", a3, 64'sd1 <<< cfg_o[15:10]);
    end
    dones = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    chk(dones == 1, inject ? "R8 single done" : "R7 one pulse", dones, 1);
    chk(cfg_o == ecfg, "R7 hold", cfg_o, ecfg);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk(cfg_o == 0 && rate_act_o == 0 && !done_o && !err_o, "R9 reset", cfg_o, 0);
    rst = 0;
    // R1
    run(0, 0);
    run(65537, 0);
    run(131071, 0);
    run(65536, 0);
    run(65535, 0);
    for (int k = 0; k <= 16; k++) run(1 << k, 0);
    for (int r = 1; r <= 1200; r++) run(r, 0);
    for (int r = 4090; r <= 4100; r++) run(r, 0);
    run(50000, 0);
    run(33333, 0);
    // R8
    run(1000, 1);
    run(65536, 1);
    run(0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule